// File: doc/BRIEF.md
# Pattern Tile Transformer

This block sits on the pattern fetch path between the video processor and a pattern ROM that holds only half of the pattern space. A single control bit picks, for each fetch, either the stored tile or a derived variant of it. The variant is produced by XOR on address lines or on data lines, or by reversing the bit order of the fetched data. The derived tiles are never stored, so a 4 KiB ROM presents an 8 KiB pattern space.

A 2-bit mode input selects one of four transforms: exchange of colours 1 and 2, vertical flip, horizontal flip, or full colour inversion. By default the control bit is PPU address line A11, so the upper half of each 4 KiB table shows transformed copies of the lower half. The control bit can instead come from a one-bit register that the CPU writes. In that case every fetched tile is transformed together. The address and data paths are combinational, and only the register is clocked.

Top module: `tile_xform`

## Requirements
- R1: After reset the control register holds 0. With the register selected as the source and mode 11, `ppu_data` then equals `rom_data`.
- R2: `rom_addr[11]` equals `ppu_addr[12]`. `rom_addr[10:0]` equals `ppu_addr[10:0]`, except for the bits that the selected mode alters. `ppu_addr[11]` never reaches the ROM address.
- R3: In mode 00 (colour swap), `rom_addr[3]` is `ppu_addr[3]` XOR the control bit.
- R4: In mode 01 (vertical flip), `rom_addr[2:0]` is `ppu_addr[2:0]` XOR the control bit copied into all three positions. With the control bit at 1 this gives row 7 minus the row.
- R5: In mode 10 (horizontal flip), `ppu_data[i]` equals `rom_data[7-i]` when the control bit is 1. When the control bit is 0, `ppu_data` equals `rom_data`.
- R6: In mode 11 (inversion), every bit of `ppu_data` is the matching bit of `rom_data` XOR the control bit.
- R7: When `ctl_src_sel` is 0, the control bit is `ppu_addr[11]`. When `ctl_src_sel` is 1, the control bit is the register and `ppu_addr[11]` has no effect on either output.
- R8: On a rising clock edge with `cpu_wr` high, the register takes the value of `cpu_wd`. With `cpu_wr` low, the register holds its value whatever `cpu_wd` does.
- R9: Modes 00 and 01 pass `rom_data` to `ppu_data` unchanged. Modes 10 and 11 leave the ROM address untransformed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Active-low asynchronous reset |
| ppu_addr | input | 13 | Pattern fetch address from the video processor |
| mode | input | 2 | Transform select: 00 swap, 01 vflip, 10 hflip, 11 invert |
| ctl_src_sel | input | 1 | 0: control bit from address A11; 1: from register |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wd | input | 1 | Register write value |
| rom_addr | output | 12 | Address to the half-size pattern ROM |
| rom_data | input | 8 | Data returned by the ROM |
| ppu_data | output | 8 | Transformed data to the video processor |

## Verification
The following are checked on every cycle:
- the register's load and hold behaviour,
- clean data pass-through in the address modes,
- clean address pass-through in the data modes,
- bit reversal, and inversion as all-or-nothing.

The bench's scenarios are needed to show that each transform produces the correct tile:
- the exact ROM addresses for swapped and flipped rows,
- that A11 is dropped from the ROM address,
- that the source select makes A11 irrelevant,
- the reset value of the register observed through the data path.

// File: rtl/tile_xform.sv
module tile_xform #(
  parameter int PPU_AW  = 13,
  parameter int ROM_AW  = 12,
  parameter int DW      = 8,
  parameter int CTL_BIT = 11,
  parameter int SWAP_BIT = 3,
  parameter int ROW_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic [1:0]        mode,
  input  logic              ctl_src_sel,
  input  logic              cpu_wr,
  input  logic              cpu_wd,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DW-1:0]     rom_data,
  output logic [DW-1:0]     ppu_data
);
  localparam logic [1:0] M_SWAP = 2'b00;
  localparam logic [1:0] M_VFLP = 2'b01;
  localparam logic [1:0] M_HFLP = 2'b10;
  localparam logic [1:0] M_INV  = 2'b11;

  logic ctl_q;
  logic ctl;
  logic [CTL_BIT-1:0] low_in, low_out;
  logic [DW-1:0] rev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= 1'b0;
    else if (cpu_wr) ctl_q <= cpu_wd;

  assign ctl    = ctl_src_sel ? ctl_q : ppu_addr[CTL_BIT];
  assign low_in = ppu_addr[CTL_BIT-1:0];

  always_comb begin
    low_out = low_in;
    if (mode == M_SWAP) low_out[SWAP_BIT] = low_in[SWAP_BIT] ^ ctl;
    if (mode == M_VFLP) low_out[ROW_W-1:0] = low_in[ROW_W-1:0] ^ {ROW_W{ctl}};
  end

  assign rom_addr = {ppu_addr[PPU_AW-1:CTL_BIT+1], low_out};

  generate
    for (genvar i = 0; i < DW; i++) begin : g_rev
      assign rev[i] = rom_data[DW-1-i];
    end
  endgenerate

  always_comb begin
    case (mode)
      M_HFLP:  ppu_data = ctl ? rev : rom_data;
      M_INV:   ppu_data = rom_data ^ {DW{ctl}};
      default: ppu_data = rom_data;
    endcase
  end

  p_latch_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> ctl_q == $past(cpu_wd));
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(ctl_q));
  p_data_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |-> ppu_data == rom_data);
  p_addr_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> rom_addr == {ppu_addr[PPU_AW-1:CTL_BIT+1], ppu_addr[CTL_BIT-1:0]});
  p_hflip_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HFLP && ctl) |-> (ppu_data[DW-1] == rom_data[0] && ppu_data[0] == rom_data[DW-1]));
  p_inv_whole_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_INV |-> ($countones(ppu_data ^ rom_data) == 0 || $countones(ppu_data ^ rom_data) == DW));
  p_row_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_VFLP |-> rom_addr[ROM_AW-1:ROW_W] == {ppu_addr[PPU_AW-1:CTL_BIT+1], ppu_addr[CTL_BIT-1:ROW_W]});
endmodule

// File: tb/tile_xform_bench.sv
module tile_xform_bench;
  logic clk = 0, rst_n = 0;
  logic [12:0] ppu_addr = '0;
  logic [1:0]  mode = '0;
  logic ctl_src_sel = 0, cpu_wr = 0, cpu_wd = 0;
  logic [11:0] rom_addr;
  logic [7:0]  rom_data = '0, ppu_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tile_xform u_tile_xform (.clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr), .mode(mode),
    .ctl_src_sel(ctl_src_sel), .cpu_wr(cpu_wr), .cpu_wd(cpu_wd),
    .rom_addr(rom_addr), .rom_data(rom_data), .ppu_data(ppu_data));

  // {mode, ppu_addr, rom_data, expected rom_addr, expected ppu_data}
  localparam logic [42:0] VEC [10] = '{
    {2'd0, 13'h0808, 8'h5A, 12'h000, 8'h5A},
    {2'd0, 13'h1003, 8'h3C, 12'h803, 8'h3C},
    {2'd1, 13'h0A05, 8'h81, 12'h202, 8'h81},
    {2'd1, 13'h1206, 8'h11, 12'hA06, 8'h11},
    {2'd2, 13'h0801, 8'h01, 12'h001, 8'h80},
    {2'd2, 13'h1803, 8'hC4, 12'h803, 8'h23},
    {2'd2, 13'h0010, 8'hC4, 12'h010, 8'hC4},
    {2'd3, 13'h0FFF, 8'h96, 12'h7FF, 8'h69},
    {2'd3, 13'h07FF, 8'h96, 12'h7FF, 8'h96},
    {2'd0, 13'h1FFF, 8'hFF, 12'hFF7, 8'hFF}
  };

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic src, input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    mode = m; ctl_src_sel = src; ppu_addr = a; rom_data = d;
    #5;
  endtask

  task automatic wr(input logic v);
    @(negedge clk); cpu_wr = 1; cpu_wd = v;
    @(negedge clk); cpu_wr = 0; cpu_wd = ~v;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1: register reset to 0, inversion via register does nothing
    apply(2'd3, 1'b1, 13'h0800, 8'hA5);
    chk("R1 reset data", {4'h0, ppu_data}, {4'h0, 8'hA5});
    // R2..R6, R9: table walk with A11 as control (R7 default source)
    for (int i = 0; i < 10; i++) begin
      apply(VEC[i][42:41], 1'b0, VEC[i][40:28], VEC[i][27:20]);
      chk("R2-map/R3/R4 addr", rom_addr, VEC[i][19:8]);
      chk("R5/R6/R9 data", {4'h0, ppu_data}, {4'h0, VEC[i][7:0]});
    end
    // R8: load 1 into register
    wr(1'b1);
    apply(2'd3, 1'b1, 13'h0000, 8'hA5);
    chk("R8 load, R7 reg source inv", {4'h0, ppu_data}, {4'h0, 8'h5A});
    apply(2'd3, 1'b1, 13'h0800, 8'hA5);
    chk("R7 A11 ignored with reg source", {4'h0, ppu_data}, {4'h0, 8'h5A});
    apply(2'd1, 1'b1, 13'h0800, 8'h00);
    chk("R7 R4 reg vflip addr", rom_addr, 12'h007);
    apply(2'd1, 1'b1, 13'h0000, 8'h00);
    chk("R7 A11 ignored addr", rom_addr, 12'h007);
    // R8: hold while strobe low and data toggles
    @(negedge clk); cpu_wd = 0;
    @(negedge clk); cpu_wd = 1;
    @(negedge clk); cpu_wd = 0;
    apply(2'd2, 1'b1, 13'h0000, 8'h0F);
    chk("R8 hold, R5 reg hflip", {4'h0, ppu_data}, {4'h0, 8'hF0});
    // R8: load 0
    wr(1'b0);
    apply(2'd3, 1'b1, 13'h0800, 8'h3C);
    chk("R8 load zero", {4'h0, ppu_data}, {4'h0, 8'h3C});
    apply(2'd0, 1'b1, 13'h0808, 8'h00);
    chk("R3 R7 reg zero swap", rom_addr, 12'h008);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule